// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers up to 128 level-sensitive interrupt sources into one interrupt request for a processor. The sources are grouped in banks of 32. Each source has a mask bit and a six-bit priority. When an unmasked source at a priority below the programmable threshold is seen while the controller is idle, a sort window of fixed length starts. At the end of the window the chosen source number is published in the active-number register and the request output goes high. The request stays high until software writes the acknowledge bit. The acknowledge also re-arms the sorter.

If the chosen source drops its level during the window, or any mask bit changes during the window, the result is still published and the request still rises. In that case the upper bits of the active-number register read as all ones, so software can discard the result and acknowledge it. Writes are taken through a simple synchronous port with a privilege flag, and reads are combinational. A write-protect bit can lock out unprivileged writers. A soft reset restores every register and reports through a done bit when it has finished.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1 (masked), threshold 0x68 reads 0xFF, protection 0x4C reads 0, config 0x10 reads 0, status 0x14 reads 1, active 0x40 reads 0xFFFFFF80, and irqOut is low.
- R2: The identification register at 0x00 reads {24'b0, major[3:0], minor[3:0]}; the default is 0x51.
- R3: Bank b has its mask at 0x84+0x20*b (write replaces, read returns, 1 = masked), mask-clear at 0x88+0x20*b, and mask-set at 0x8C+0x20*b. Each 1 bit clears or sets the matching mask bit, and 0 bits leave it unchanged.
- R4: Pending at 0x98+0x20*b reads the bank's input levels ANDed with the inverted mask.
- R5: When an eligible source exists while idle, a sort starts at the next clock edge. irqOut rises exactly SORT_CYCLES (10) edges after that edge.
- R6: While a result is held, 0x40 returns the source number in bits 6:0, with bits 31:7 zero for a valid sort. While no result is held, 0x40 reads 0xFFFFFF80.
- R7: The priority of source n is written at 0x100+4*n, bits 7:2; the other bits read 0. The lowest priority value wins, and on a tie the lowest source number wins.
- R8: A source is eligible only if its level is high, it is unmasked, and its priority is below the threshold at 0x68 (bits 7:0).
- R9: Writing 1 to bit 0 of 0x48 while irqOut is high drops irqOut at that edge and re-arms sorting. The same write while idle or sorting is ignored.
- R10: If the chosen source's level is low, or any mask bit changes, on any edge of the window, the published result has bits 31:7 all ones, and irqOut still rises and holds until acknowledged.
- R11: Bit 0 of 0x4C is stored. While it is 1, every write with busPriv low is ignored.
- R12: Writing 1 to bit 1 of 0x10 makes 0x14 bit 0 read 0 for one cycle. On the next edge all registers return to their reset values, any held result is dropped, and 0x14 bit 0 reads 1. Bit 0 of 0x10 is stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcLevel | input | NUM_SRC | Level of each interrupt source |
| busAddr | input | 12 | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busPriv | input | 1 | Writer is privileged |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Most internal faults show up at the ports within one sort window. A miscounted window moves the rise of irqOut by one edge or more. A wrong candidate or a lost drop/mask-change flag changes the active-number word on the cycle the request rises. A corrupt mask or priority register appears immediately on read-back, and later as a different winner. Because a reference model is compared on every clock, a divergence in the soft-reset sequence or in the handling of the protection bit is reported on the first cycle on which the status, a register read or irqOut differs.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_SORT, ST_HOLD} sortState_e;

  typedef struct packed {
    logic startSort;
    logic trackSort;
    logic publish;
    logic ackDone;
    logic softRst;
  } ctrlStrobe_t;

  localparam int unsigned OFF_IDENT   = 32'h000;
  localparam int unsigned OFF_CFG     = 32'h010;
  localparam int unsigned OFF_STAT    = 32'h014;
  localparam int unsigned OFF_ACTIVE  = 32'h040;
  localparam int unsigned OFF_ACK     = 32'h048;
  localparam int unsigned OFF_PROT    = 32'h04C;
  localparam int unsigned OFF_THRESH  = 32'h068;
  localparam int unsigned OFF_MASK    = 32'h084;
  localparam int unsigned OFF_MCLR    = 32'h088;
  localparam int unsigned OFF_MSET    = 32'h08C;
  localparam int unsigned OFF_PEND    = 32'h098;
  localparam int unsigned BANK_STRIDE = 32'h020;
  localparam int unsigned OFF_PRIO    = 32'h100;

endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int ADDR_W    = 12,
  parameter int REV_MAJOR = 5,
  parameter int REV_MINOR = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busPriv,
  output logic [31:0]        busRdData,
  output logic               anyElig,
  output logic               ackReq,
  output logic               softReq,
  output logic               resValid
);
  localparam int BANKS = NUM_SRC / 32;
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] maskQ, maskD, elig;
  logic [5:0]         prioQ [NUM_SRC];
  logic [7:0]         thrQ;
  logic               protQ, cfgQ, doneQ;
  logic [IDX_W-1:0]   candQ, winIdx, prioIdx;
  logic               spurQ, resSpurQ, resValidQ, candDrop, wrOk, prioHit;
  logic [ADDR_W-1:0]  prioOff;
  logic [5:0]         bestPrio;

  assign wrOk    = busWrEn & (~protQ | busPriv);
  assign softReq = wrOk && busAddr == ADDR_W'(OFF_CFG) && busWrData[1];
  assign ackReq  = wrOk && busAddr == ADDR_W'(OFF_ACK) && busWrData[0];
  assign prioOff = busAddr - ADDR_W'(OFF_PRIO);
  assign prioIdx = prioOff[IDX_W+1:2];
  assign prioHit = busAddr >= ADDR_W'(OFF_PRIO) &&
                   busAddr < ADDR_W'(OFF_PRIO + 4 * NUM_SRC) && busAddr[1:0] == 2'b00;

  // next mask value from the three per-bank write views
  always_comb begin
    maskD = maskQ;
    for (int b = 0; b < BANKS; b++) begin
      if (wrOk && busAddr == ADDR_W'(OFF_MASK + b * BANK_STRIDE))
        maskD[b*32 +: 32] = busWrData;
      if (wrOk && busAddr == ADDR_W'(OFF_MCLR + b * BANK_STRIDE))
        maskD[b*32 +: 32] = maskQ[b*32 +: 32] & ~busWrData;
      if (wrOk && busAddr == ADDR_W'(OFF_MSET + b * BANK_STRIDE))
        maskD[b*32 +: 32] = maskQ[b*32 +: 32] | busWrData;
    end
  end

  // per-source priority storage and eligibility
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            prioQ[i] <= '0;
      else if (strb.softRst)                                prioQ[i] <= '0;
      else if (wrOk && prioHit && prioIdx == IDX_W'(i))     prioQ[i] <= busWrData[7:2];
    end
    assign elig[i] = srcLevel[i] & ~maskQ[i] & ({2'b00, prioQ[i]} < thrQ);
  end

  // winner: strictly lower value replaces, so ties keep the lower number
  always_comb begin
    winIdx   = '0;
    bestPrio = 6'h3F;
    anyElig  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!anyElig || prioQ[i] < bestPrio)) begin
        anyElig  = 1'b1;
        bestPrio = prioQ[i];
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign candDrop = ~srcLevel[candQ] | (maskD != maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      thrQ  <= 8'hFF;
      protQ <= 1'b0;
      cfgQ  <= 1'b0;
      doneQ <= 1'b1;
    end else begin
      if (strb.softRst) begin
        maskQ <= '1;
        thrQ  <= 8'hFF;
        protQ <= 1'b0;
        cfgQ  <= 1'b0;
      end else begin
        maskQ <= maskD;
        if (wrOk && busAddr == ADDR_W'(OFF_THRESH)) thrQ  <= busWrData[7:0];
        if (wrOk && busAddr == ADDR_W'(OFF_PROT))   protQ <= busWrData[0];
        if (wrOk && busAddr == ADDR_W'(OFF_CFG))    cfgQ  <= busWrData[0];
      end
      if (softReq)           doneQ <= 1'b0;
      else if (strb.softRst) doneQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ     <= '0;
      spurQ     <= 1'b0;
      resSpurQ  <= 1'b0;
      resValidQ <= 1'b0;
    end else if (strb.softRst) begin
      spurQ     <= 1'b0;
      resSpurQ  <= 1'b0;
      resValidQ <= 1'b0;
    end else begin
      if (strb.startSort) begin
        candQ <= winIdx;
        spurQ <= 1'b0;
      end
      if (strb.trackSort) spurQ <= spurQ | candDrop;
      if (strb.publish) begin
        resSpurQ  <= spurQ | candDrop;
        resValidQ <= 1'b1;
      end
      if (strb.ackDone) resValidQ <= 1'b0;
    end
  end

  assign resValid = resValidQ;

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(OFF_IDENT))  busRdData = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
    if (busAddr == ADDR_W'(OFF_CFG))    busRdData = {31'd0, cfgQ};
    if (busAddr == ADDR_W'(OFF_STAT))   busRdData = {31'd0, doneQ};
    if (busAddr == ADDR_W'(OFF_PROT))   busRdData = {31'd0, protQ};
    if (busAddr == ADDR_W'(OFF_THRESH)) busRdData = {24'd0, thrQ};
    if (busAddr == ADDR_W'(OFF_ACTIVE))
      busRdData = resValidQ ? {resSpurQ ? 25'h1FF_FFFF : 25'h0, 7'(candQ)} : 32'hFFFF_FF80;
    for (int b = 0; b < BANKS; b++) begin
      if (busAddr == ADDR_W'(OFF_MASK + b * BANK_STRIDE)) busRdData = maskQ[b*32 +: 32];
      if (busAddr == ADDR_W'(OFF_PEND + b * BANK_STRIDE))
        busRdData = srcLevel[b*32 +: 32] & ~maskQ[b*32 +: 32];
    end
    if (prioHit) busRdData = {24'd0, prioQ[prioIdx], 2'b00};
  end

  AST_PROT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (protQ && busWrEn && !busPriv && !strb.softRst) |=> ($stable(thrQ) && $stable(maskQ) && protQ)); // R11

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (resValidQ && !strb.ackDone && !strb.softRst) |=> (resValidQ && $stable(candQ) && $stable(resSpurQ))); // R6

endmodule

// File: rtl/prio_irq_sorter.sv
module prio_irq_sorter
  import prio_irq_pkg::*;
#(
  parameter int SORT_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyElig,
  input  logic        ackReq,
  input  logic        softReq,
  output ctrlStrobe_t strb,
  output logic        irqOut
);
  localparam int CNT_W = $clog2(SORT_CYCLES + 1);

  sortState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             pendQ;

  assign strb.softRst   = pendQ;
  assign strb.startSort = (state == ST_IDLE) && anyElig && !pendQ;
  assign strb.trackSort = (state == ST_SORT) && !pendQ;
  assign strb.publish   = (state == ST_SORT) && (cnt == CNT_W'(SORT_CYCLES)) && !pendQ;
  assign strb.ackDone   = (state == ST_HOLD) && ackReq && !pendQ;
  assign irqOut         = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pendQ <= 1'b0;
    end else begin
      pendQ <= softReq;
      if (pendQ) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: if (anyElig) begin
            state <= ST_SORT;
            cnt   <= CNT_W'(1);
          end
          ST_SORT: if (cnt == CNT_W'(SORT_CYCLES)) state <= ST_HOLD;
                   else cnt <= cnt + 1'b1;
          ST_HOLD: if (ackReq) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SORT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SORT) |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(SORT_CYCLES))); // R5

  AST_IRQ_AFTER_SORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(state) == ST_SORT && $past(cnt) == CNT_W'(SORT_CYCLES))); // R5

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && ackReq && !pendQ) |=> !irqOut); // R9

  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |=> (state == ST_IDLE && !irqOut)); // R12

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC     = 128,
  parameter int ADDR_W      = 12,
  parameter int SORT_CYCLES = 10,
  parameter int REV_MAJOR   = 5,
  parameter int REV_MINOR   = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  input  logic               busPriv,
  output logic [31:0]        busRdData,
  output logic               irqOut
);
  ctrlStrobe_t strb;
  logic        anyElig, ackReq, softReq, resValid;

  prio_irq_sorter #(.SORT_CYCLES(SORT_CYCLES)) u_sorter (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .ackReq(ackReq),
    .softReq(softReq), .strb(strb), .irqOut(irqOut)
  );

  prio_irq_datapath #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .srcLevel(srcLevel),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData), .busPriv(busPriv),
    .busRdData(busRdData), .anyElig(anyElig), .ackReq(ackReq), .softReq(softReq),
    .resValid(resValid)
  );

  AST_IRQ_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == resValid); // R10

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;
  localparam int WIN = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic [NSRC-1:0]  srcLevel;
  logic [11:0]      busAddr;
  logic             busWrEn;
  logic [31:0]      busWrData;
  logic             busPriv;
  logic [31:0]      busRdData;
  logic             irqOut;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;
  string curReq = "R1";

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busPriv(busPriv),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [NSRC-1:0] mMask, nm;
  int   mPrio [NSRC];
  int   mThr, mState, mCnt, mCand, best, w;
  bit   mProt, mCfg, mDone, mPend, mSpur, mRSpur, wok, softR, ackR, anyE, drop;

  task automatic mClear();
    mMask = '1; mThr = 255; mProt = 0; mCfg = 0;
    for (int i = 0; i < NSRC; i++) mPrio[i] = 0;
    mState = 0; mCnt = 0; mSpur = 0; mRSpur = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mClear(); mDone = 1; mPend = 0; mCand = 0;
    end else begin
      wok   = busWrEn && (!mProt || busPriv);
      softR = wok && busAddr == 12'h010 && busWrData[1];
      ackR  = wok && busAddr == 12'h048 && busWrData[0];
      nm = mMask;
      if (wok) for (int b = 0; b < NSRC/32; b++) begin
        if (busAddr == 12'(32'h84 + 32*b)) nm[b*32 +: 32] = busWrData;
        if (busAddr == 12'(32'h88 + 32*b)) nm[b*32 +: 32] = nm[b*32 +: 32] & ~busWrData;
        if (busAddr == 12'(32'h8C + 32*b)) nm[b*32 +: 32] = nm[b*32 +: 32] | busWrData;
      end
      anyE = 0; best = 99; w = 0;
      for (int i = 0; i < NSRC; i++)
        if (srcLevel[i] && !mMask[i] && mPrio[i] < mThr && mPrio[i] < best) begin
          anyE = 1; best = mPrio[i]; w = i;
        end
      drop = !srcLevel[mCand] || (nm != mMask);
      if (mPend) begin
        mClear(); mDone = 1;
      end else begin
        case (mState)
          0: if (anyE) begin mCand = w; mSpur = 0; mState = 1; mCnt = 1; end
          1: begin
               mSpur = mSpur | drop;
               if (mCnt == WIN) begin mRSpur = mSpur; mState = 2; end else mCnt++;
             end
          default: if (ackR) mState = 0;
        endcase
        mMask = nm;
        if (wok && busAddr == 12'h068) mThr = busWrData[7:0];
        if (wok && busAddr == 12'h04C) mProt = busWrData[0];
        if (wok && busAddr == 12'h010) mCfg = busWrData[0];
        if (wok && busAddr >= 12'h100 && busAddr < 12'h300 && busAddr[1:0] == 0)
          mPrio[(busAddr - 12'h100) >> 2] = busWrData[7:2];
      end
      mPend = softR;
      if (softR) mDone = 0;
    end
  end

  function automatic logic [31:0] mRead(input logic [11:0] a);
    logic [31:0] r = 0;
    if (a == 12'h000) r = 32'h51;
    if (a == 12'h010) r = {31'd0, mCfg};
    if (a == 12'h014) r = {31'd0, mDone};
    if (a == 12'h04C) r = {31'd0, mProt};
    if (a == 12'h068) r = 32'(mThr);
    if (a == 12'h040) r = (mState == 2) ? ((mRSpur ? 32'hFFFF_FF80 : 0) | 32'(mCand)) : 32'hFFFF_FF80;
    for (int b = 0; b < NSRC/32; b++) begin
      if (a == 12'(32'h84 + 32*b)) r = mMask[b*32 +: 32];
      if (a == 12'(32'h98 + 32*b)) r = srcLevel[b*32 +: 32] & ~mMask[b*32 +: 32];
    end
    if (a >= 12'h100 && a < 12'h300 && a[1:0] == 0) r = 32'(mPrio[(a - 12'h100) >> 2]) << 2;
    return r;
  endfunction

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vectors++;
      if (busRdData !== mRead(busAddr) || irqOut !== (mState == 2)) begin
        miscompares++;
        $display("FAIL %s model compare addr=%h rd act=%h exp=%h irq act=%0b exp=%0b",
                 curReq, busAddr, busRdData, mRead(busAddr), irqOut, mState == 2);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p = 1'b1);
    busAddr = a; busWrData = d; busPriv = p; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busPriv = 1'b1;
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    @(negedge clk);
    vectors++;
    if (busRdData !== exp) begin
      miscompares++;
      $display("FAIL %s read %h act=%h exp=%h", tag, a, busRdData, exp);
    end
    tick();
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    vectors++;
    if (irqOut !== exp) begin
      miscompares++;
      $display("FAIL %s irqOut act=%0b exp=%0b", tag, irqOut, exp);
    end
    tick();
  endtask

  task automatic waitIrq(input string tag);
    bit seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (irqOut) seen = 1;
      tick();
    end
    vectors++;
    if (!seen) begin
      miscompares++;
      $display("FAIL %s irqOut act=0 exp=1 (never rose)", tag);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
    end
  end

  initial begin
    rstN = 1'b0; srcLevel = '0; busAddr = '0; busWrEn = 1'b0; busWrData = '0; busPriv = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    curReq = "R1";
    chk(12'h084, 32'hFFFF_FFFF, "R1"); chk(12'h0E4, 32'hFFFF_FFFF, "R1");
    chk(12'h068, 32'hFF, "R1");        chk(12'h04C, 0, "R1");
    chk(12'h010, 0, "R1");             chk(12'h014, 1, "R1");
    chk(12'h040, 32'hFFFF_FF80, "R1"); chkIrq(1'b0, "R1");

    curReq = "R2";
    chk(12'h000, 32'h51, "R2");

    curReq = "R3";
    wr(12'h088, 32'hF0);       chk(12'h084, 32'hFFFF_FF0F, "R3");
    wr(12'h08C, 32'h10);       chk(12'h084, 32'hFFFF_FF1F, "R3");
    wr(12'h08C, 0); wr(12'h088, 0); chk(12'h084, 32'hFFFF_FF1F, "R3");
    wr(12'h084, 32'hFFFF_FFFF); chk(12'h084, 32'hFFFF_FFFF, "R3");

    curReq = "R4";
    srcLevel[63:32] = 32'h0000_F00F;
    wr(12'h0A8, 32'hFF);
    chk(12'h0B8, 32'h0000_000F, "R4");
    waitIrq("R4");
    chk(12'h040, 32'h20, "R6");
    wr(12'h048, 1); chkIrq(1'b0, "R9");
    curReq = "R10";
    wr(12'h0AC, 32'hFF);
    waitIrq("R10");
    chk(12'h040, 32'hFFFF_FFA0, "R10");
    srcLevel[63:32] = '0;
    wr(12'h048, 1);

    curReq = "R5";
    srcLevel[5] = 1'b1;
    wr(12'h088, 32'h20);
    repeat (WIN) tick();
    chkIrq(1'b0, "R5");
    chkIrq(1'b1, "R5");
    chk(12'h040, 32'h05, "R6");
    curReq = "R9";
    wr(12'h048, 1); chkIrq(1'b0, "R9");
    wr(12'h048, 1);
    waitIrq("R9");
    chk(12'h040, 32'h05, "R9");
    srcLevel[5] = 1'b0;
    wr(12'h048, 1);
    repeat (3) tick();
    chkIrq(1'b0, "R9");

    curReq = "R7";
    wr(12'h114, 32'h28); wr(12'h218, 32'h08);
    chk(12'h218, 32'h08, "R7");
    wr(12'h11C, 32'hFF); chk(12'h11C, 32'hFC, "R7");
    wr(12'h0C8, 32'h40);
    srcLevel[5] = 1'b1; srcLevel[70] = 1'b1;
    waitIrq("R7");
    chk(12'h040, 32'h46, "R7");
    wr(12'h048, 1);
    wr(12'h218, 32'h28);
    waitIrq("R7");
    chk(12'h040, 32'h46, "R7");
    wr(12'h048, 1);
    waitIrq("R7");
    chk(12'h040, 32'h05, "R7");
    srcLevel[5] = 1'b0; srcLevel[70] = 1'b0;
    wr(12'h048, 1);

    curReq = "R8";
    wr(12'h068, 32'h0A);
    srcLevel[5] = 1'b1; srcLevel[70] = 1'b1;
    repeat (15) tick();
    chkIrq(1'b0, "R8");
    chk(12'h040, 32'hFFFF_FF80, "R8");
    wr(12'h068, 32'h0B);
    waitIrq("R8");
    chk(12'h040, 32'h05, "R8");
    srcLevel[5] = 1'b0; srcLevel[70] = 1'b0;
    wr(12'h048, 1);
    wr(12'h068, 32'hFF);

    curReq = "R10";
    srcLevel[40] = 1'b1;
    wr(12'h0A8, 32'h100);
    repeat (3) tick();
    srcLevel[40] = 1'b0;
    waitIrq("R10");
    chk(12'h040, 32'hFFFF_FFA8, "R10");
    chkIrq(1'b1, "R10");
    wr(12'h048, 1);

    curReq = "R11";
    wr(12'h04C, 1, 1'b1);              chk(12'h04C, 1, "R11");
    wr(12'h068, 32'h03, 1'b0);         chk(12'h068, 32'hFF, "R11");
    wr(12'h08C, 32'hFFFF_FFFF, 1'b0);  chk(12'h084, 32'hFFFF_FFDF, "R11");
    wr(12'h068, 32'h03, 1'b1);         chk(12'h068, 32'h03, "R11");
    wr(12'h068, 32'hFF, 1'b1);
    wr(12'h04C, 0, 1'b0);              chk(12'h04C, 1, "R11");
    wr(12'h04C, 0, 1'b1);              chk(12'h04C, 0, "R11");

    curReq = "R6";
    srcLevel[127] = 1'b1;
    wr(12'h0E8, 32'h8000_0000);
    waitIrq("R6");
    chk(12'h040, 32'h7F, "R6");
    srcLevel[127] = 1'b0;
    wr(12'h048, 1);

    curReq = "R12";
    wr(12'h010, 1); chk(12'h010, 1, "R12");
    srcLevel[5] = 1'b1;
    waitIrq("R12");
    wr(12'h010, 32'h2);
    chk(12'h014, 0, "R12");
    chk(12'h014, 1, "R12");
    chkIrq(1'b0, "R12");
    chk(12'h084, 32'hFFFF_FFFF, "R12");
    chk(12'h114, 0, "R12");
    chk(12'h010, 0, "R12");
    chk(12'h068, 32'hFF, "R12");
    chk(12'h040, 32'hFFFF_FF80, "R12");
    srcLevel[5] = 1'b0;
    repeat (4) tick();
    summary();
  end

endmodule